// File: doc/BRIEF.md
# EDO DRAM access cycle sequencer

This block turns a request from a clocked on-chip bus into the signal sequence that an asynchronous DRAM expects. A request carries a combined row/column address, a read/write flag, a beat count and write data. The block then steps through a fixed chain of named states. Two row states drive the row address and pull RAS low. The column states follow, once per beat, driving the column address and pulsing CAS. A column-end state comes next, and a precharge state returns RAS high. The address bus is shared, so the row and the column take turns on it.

A configuration input picks fast-page or extended-data-out timing. In fast-page mode a read is sampled on the last clock edge of the CAS-low time. In extended-data-out mode it is sampled one cycle later, after CAS has gone high again, because the memory holds its output until the next CAS fall. Further inputs set four timings: the CAS-high time before each beat, the extra RAS-to-CAS cycles, the extra CAS-low cycles for writes, and the precharge length. Some combinations are illegal. The block flags them and refuses requests while they are present.

Top module: `edo_seq_top`

## Requirements
- R1: After reset, ras_n, cas_n and we_n are high, and busy, rd_valid, done and dq_oe are low.
- R2: An accepted access passes through the states row-1, row-2, column-1, column-2 (column-1/column-2 repeated per beat), column-end and precharge, in that order. ras_n falls exactly once per access and stays low from row-2 through column-end. cas_n falls once per beat.
- R3: ma carries the row (req_addr upper ROW_W bits) when ras_n falls. At the fall of cas_n for beat k (k from 0) it carries (column + k) modulo 2^COL_W, where the column is req_addr lower COL_W bits.
- R4: With cfg_edo=0, read data is captured on the clock edge that ends the CAS-low time of each beat.
- R5: With cfg_edo=1, read data is captured one clock later, on an edge ending a cycle in which cas_n is high.
- R6: cfg_err is high when cfg_edo=1 with cfg_burst=0, or when cfg_tpc=0. While cfg_err is high, req_valid is ignored: busy stays low and ras_n never falls.
- R7: With cfg_burst=1 an access has req_len+1 beats. With cfg_burst=0 it has one beat, whatever req_len is.
- R8: Before every CAS-low time, cas_n is high with ras_n low for 1 cycle if cfg_tcas2=0 and for 2 cycles if cfg_tcas2=1. The column-end state adds one more such cycle.
- R9: From the fall of ras_n, 1+cfg_rcd row cycles plus the first CAS-high time pass before cas_n first falls.
- R10: Each CAS-low time lasts 1 cycle for reads and 1+cfg_wwait cycles for writes.
- R11: After the column-end state, ras_n stays high for cfg_tpc cycles with busy still high. An access keeps busy high for 2+cfg_rcd+beats*(CAS-high+CAS-low)+1+cfg_tpc cycles.
- R12: For writes, we_n is low during the column states. While cas_n is low, dq_oe is high and dq_out holds the wdata presented during that beat's column-1 state, where beat_idx gives the beat number.
- R13: done pulses for one cycle once per completed beat. For reads, rd_valid pulses once per beat with the captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle and configuration legal |
| req_write | input | 1 | 1 = write access |
| req_addr | input | ROW_W+COL_W | Row in upper bits, starting column in lower bits |
| req_len | input | LEN_W | Beats minus one |
| wdata | input | DW | Write data for the beat shown on beat_idx |
| cfg_edo | input | 1 | 1 = extended-data-out read timing |
| cfg_burst | input | 1 | Burst enable |
| cfg_tcas2 | input | 1 | CAS-high time: 0 = 1 cycle, 1 = 2 cycles |
| cfg_rcd | input | 2 | Extra RAS-to-CAS cycles |
| cfg_wwait | input | 2 | Extra CAS-low cycles on writes |
| cfg_tpc | input | 2 | Precharge cycles (0 illegal) |
| dq_in | input | DW | Read data from the DRAM |
| busy | output | 1 | Access in progress |
| cfg_err | output | 1 | Illegal configuration |
| beat_idx | output | LEN_W | Current beat number |
| ma | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | DW | Write data to the DRAM |
| dq_oe | output | 1 | Write data drive enable |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | DW | Captured read data |
| done | output | 1 | One pulse per completed beat |

## Verification
In extended-data-out bursts, the late capture of beat k falls in the same cycle as the CAS-high state of beat k+1. In that cycle the column address on ma has already moved on to the next column. The late capture of the final beat falls in the column-end cycle instead. The bench provokes both overlaps with random bursts at the one-cycle CAS-high setting. Its memory model changes its output only after a CAS-low cycle, so a capture taken too early or one that picks up the wrong beat shows up as a data mismatch against the row/column data function.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  localparam int TIM_W = 2;
  localparam int CNT_W = TIM_W + 1;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_TR1  = 3'd1,
    S_TR2  = 3'd2,
    S_TC1  = 3'd3,
    S_TC2  = 3'd4,
    S_TCE  = 3'd5,
    S_TPC  = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic             edo;
    logic             burst;
    logic             tcas2;
    logic [TIM_W-1:0] rcd;
    logic [TIM_W-1:0] wwait;
    logic [TIM_W-1:0] tpc;
  } seq_cfg_t;

  // cycles minus one that a state is held after entry
  function automatic logic [CNT_W-1:0] hold_of(seq_state_e s, seq_cfg_t c, logic wr);
    logic [CNT_W-1:0] h;
    case (s)
      S_TR2:   h = CNT_W'(c.rcd);
      S_TC1:   h = CNT_W'(c.tcas2);
      S_TC2:   h = wr ? CNT_W'(c.wwait) : '0;
      S_TPC:   h = CNT_W'(c.tpc) - CNT_W'(1);
      default: h = '0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/edo_seq_cfgchk.sv
module edo_seq_cfgchk
  import edo_seq_pkg::*;
(
  input  seq_cfg_t cfg,
  output logic     illegal
);
  logic edo_wo_burst;
  logic no_precharge;

  always_comb begin
    edo_wo_burst = cfg.edo & ~cfg.burst;
    no_precharge = (cfg.tpc == '0);
    illegal      = edo_wo_burst | no_precharge;
  end
endmodule

// File: rtl/edo_seq_addr.sv
module edo_seq_addr
  import edo_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int LEN_W = 3,
  parameter int MA_W  = 10
) (
  input  seq_state_e       state,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] beat,
  output logic [MA_W-1:0]  ma
);
  logic [COL_W-1:0] col_eff;

  always_comb begin
    col_eff = col + COL_W'(beat);
    case (state)
      S_TR1, S_TR2:        ma = MA_W'(row);
      S_TC1, S_TC2, S_TCE: ma = MA_W'(col_eff);
      default:             ma = '0;
    endcase
  end
endmodule

// File: rtl/edo_seq_capture.sv
module edo_seq_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edo,
  input  logic          strobe,
  input  logic          cas_n_i,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic pend, pend_nx, vld_nx, dat_ld;

  always_comb begin
    pend_nx = pend;
    vld_nx  = 1'b0;
    dat_ld  = 1'b0;
    if (pend) begin
      vld_nx  = 1'b1;
      dat_ld  = 1'b1;
      pend_nx = 1'b0;
    end
    if (strobe) begin
      if (edo) pend_nx = 1'b1;
      else begin
        vld_nx = 1'b1;
        dat_ld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pend     <= pend_nx;
      rd_valid <= vld_nx;
      if (dat_ld) rd_data <= dq_in;
    end
  end

  // R4: fast-page capture edge ends a CAS-low cycle
  a_r4_fp_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !edo) |-> !$past(cas_n_i));
  // R5: extended-data-out capture edge ends a CAS-high cycle
  a_r5_edo_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && edo) |-> $past(cas_n_i));
endmodule

// File: rtl/edo_seq_top.sv
module edo_seq_top
  import edo_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int DW    = 16,
  parameter int LEN_W = 3,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int AW   = ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [DW-1:0]    wdata,
  input  logic             cfg_edo,
  input  logic             cfg_burst,
  input  logic             cfg_tcas2,
  input  logic [1:0]       cfg_rcd,
  input  logic [1:0]       cfg_wwait,
  input  logic [1:0]       cfg_tpc,
  input  logic [DW-1:0]    dq_in,
  output logic             busy,
  output logic             cfg_err,
  output logic [LEN_W-1:0] beat_idx,
  output logic [MA_W-1:0]  ma,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             done
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  seq_cfg_t cfg_in, cfg_q;
  always_comb begin
    cfg_in.edo   = cfg_edo;
    cfg_in.burst = cfg_burst;
    cfg_in.tcas2 = cfg_tcas2;
    cfg_in.rcd   = cfg_rcd;
    cfg_in.wwait = cfg_wwait;
    cfg_in.tpc   = cfg_tpc;
  end

  edo_seq_cfgchk u_chk (
    .cfg     (cfg_in),
    .illegal (cfg_err)
  );

  seq_state_e       state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [LEN_W-1:0] beat, beat_nx, last_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic             accept, enter, cnt_zero, beat_end, dq_ld, wdone_q;

  assign cnt_zero = (cnt == '0);
  assign accept   = (state == S_IDLE) && req_valid && !cfg_err;
  assign beat_end = (state == S_TC2) && cnt_zero;
  assign dq_ld    = (state == S_TC1) && cnt_zero && wr_q;

  // next-state process
  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    beat_nx  = beat;
    enter    = 1'b0;
    if (state == S_IDLE) begin
      if (accept) begin
        state_nx = S_TR1;
        beat_nx  = '0;
        enter    = 1'b1;
      end
    end else if (!cnt_zero) begin
      cnt_nx = cnt - CNT_W'(1);
    end else begin
      enter = 1'b1;
      case (state)
        S_TR1: state_nx = S_TR2;
        S_TR2: state_nx = S_TC1;
        S_TC1: state_nx = S_TC2;
        S_TC2: begin
          if (beat == last_q) state_nx = S_TCE;
          else begin
            state_nx = S_TC1;
            beat_nx  = beat + LEN_W'(1);
          end
        end
        S_TCE:   state_nx = S_TPC;
        default: state_nx = S_IDLE;
      endcase
    end
    if (enter) cnt_nx = hold_of(state_nx, cfg_q, wr_q);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state   <= S_IDLE;
      cnt     <= '0;
      beat    <= '0;
      last_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      cfg_q   <= '0;
      dq_out  <= '0;
      wdone_q <= 1'b0;
    end else begin
      state   <= state_nx;
      cnt     <= cnt_nx;
      beat    <= beat_nx;
      wdone_q <= beat_end && wr_q;
      if (accept) begin
        last_q <= cfg_burst ? req_len : '0;
        row_q  <= req_addr[AW-1:COL_W];
        col_q  <= req_addr[COL_W-1:0];
        wr_q   <= req_write;
        cfg_q  <= cfg_in;
      end
      if (dq_ld) dq_out <= wdata;
    end
  end

  edo_seq_addr #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .LEN_W (LEN_W),
    .MA_W  (MA_W)
  ) u_addr (
    .state (state),
    .row   (row_q),
    .col   (col_q),
    .beat  (beat),
    .ma    (ma)
  );

  // strobes decoded from the state register
  always_comb begin
    busy     = (state != S_IDLE);
    ras_n    = !(state inside {S_TR2, S_TC1, S_TC2, S_TCE});
    cas_n    = (state != S_TC2);
    we_n     = !(wr_q && (state inside {S_TC1, S_TC2}));
    dq_oe    = wr_q && (state == S_TC2);
    beat_idx = beat;
  end

  logic rvalid_i;

  edo_seq_capture #(
    .DW (DW)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .edo      (cfg_q.edo),
    .strobe   (beat_end && !wr_q),
    .cas_n_i  (cas_n),
    .dq_in    (dq_in),
    .rd_valid (rvalid_i),
    .rd_data  (rd_data)
  );

  assign rd_valid = rvalid_i;
  assign done     = rvalid_i | wdone_q;

  // R2: fixed order of the row and column-end steps
  a_r2_tr1_next: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == S_TR1) |=> (state == S_TR2));
  a_r2_tce_next: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == S_TCE) |=> (state == S_TPC));
  // R2: CAS only pulses inside a RAS-low window
  a_r2_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cas_n |-> !ras_n);
  // R6: an illegal configuration keeps the sequencer idle
  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == S_IDLE && cfg_err) |=> (state == S_IDLE));
  // R12: write enable only while the row is open
  a_r12_we_in_ras: assert property (@(posedge clk) disable iff (!rst_n_s)
    !we_n |-> !ras_n);
  // R13: write beat completion gives exactly one done pulse
  a_r13_wdone: assert property (@(posedge clk) disable iff (!rst_n_s)
    (beat_end && wr_q) |=> done);
endmodule

// File: tb/tb_edo_seq_top.sv
module tb_edo_seq_top;
  localparam int ROW_W = 10;
  localparam int COL_W = 10;
  localparam int DW    = 16;
  localparam int LEN_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_write;
  logic [19:0]      req_addr;
  logic [LEN_W-1:0] req_len;
  logic [DW-1:0]    wdata, dq_in;
  logic             cfg_edo, cfg_burst, cfg_tcas2;
  logic [1:0]       cfg_rcd, cfg_wwait, cfg_tpc;
  logic             busy, cfg_err, ras_n, cas_n, we_n, dq_oe, rd_valid, done;
  logic [LEN_W-1:0] beat_idx;
  logic [9:0]       ma;
  logic [DW-1:0]    dq_out, rd_data;

  always #2.5 clk = ~clk;

  edo_seq_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wdata(wdata),
    .cfg_edo(cfg_edo), .cfg_burst(cfg_burst), .cfg_tcas2(cfg_tcas2),
    .cfg_rcd(cfg_rcd), .cfg_wwait(cfg_wwait), .cfg_tpc(cfg_tpc), .dq_in(dq_in),
    .busy(busy), .cfg_err(cfg_err), .beat_idx(beat_idx), .ma(ma),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mdat(logic [9:0] r, logic [9:0] c);
    return (16'(r) * 16'd97) ^ (16'(c) << 3) ^ 16'hA5C3;
  endfunction

  // DRAM model
  logic [9:0]  row_l = '0, col_l = '0;
  logic [15:0] edo_q = '0;
  logic        cur_edo = 1'b0;
  logic [15:0] wbase = '0;
  logic [9:0]  cur_row = '0, cur_col = '0;

  always @(negedge ras_n) row_l = ma;
  always @(negedge cas_n) col_l = ma;
  always @(posedge clk) if (!cas_n) edo_q <= mdat(row_l, col_l);
  assign dq_in = cur_edo ? edo_q : (!cas_n ? mdat(row_l, col_l) : 16'hDEAD);
  assign wdata = wbase + 16'(beat_idx) * 16'h0101;

  // monitor statistics per access
  int ras_falls, cas_falls, busy_cyc, rash_busy, first_wait, cashi, caslo;
  int rd_n, rd_bad, done_n, wr_n, wr_bad;
  bit seen_cas;
  logic prev_ras = 1'b1, prev_cas = 1'b1;

  task automatic clear_stats();
    ras_falls = 0; cas_falls = 0; busy_cyc = 0; rash_busy = 0; first_wait = 0;
    cashi = 0; caslo = 0; rd_n = 0; rd_bad = 0; done_n = 0; wr_n = 0; wr_bad = 0;
    seen_cas = 1'b0;
  endtask

  always @(posedge clk) begin
    if (busy) busy_cyc++;
    if (busy && ras_n) rash_busy++;
    if (!ras_n && prev_ras) ras_falls++;
    if (!cas_n && prev_cas) begin
      cas_falls++;
      if (!we_n) begin
        if (!dq_oe || dq_out !== wbase + 16'(wr_n) * 16'h0101 ||
            col_l !== cur_col + 10'(wr_n)) wr_bad++;
        wr_n++;
      end
    end
    if (busy && !ras_n && cas_n) begin
      cashi++;
      if (!seen_cas) first_wait++;
    end
    if (!cas_n) begin
      caslo++;
      seen_cas = 1'b1;
    end
    if (rd_valid) begin
      if (rd_data !== mdat(cur_row, cur_col + 10'(rd_n))) rd_bad++;
      rd_n++;
    end
    if (done) done_n++;
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  task automatic do_acc(input bit wr, input logic [9:0] row, input logic [9:0] col,
                        input logic [2:0] len, input bit edo, input bit be, input bit tc2,
                        input logic [1:0] rcd, input logic [1:0] wt, input logic [1:0] tpc,
                        input bit legal);
    int beats, nh, nl, exp_busy;
    @(negedge clk);
    cfg_edo = edo; cfg_burst = be; cfg_tcas2 = tc2;
    cfg_rcd = rcd; cfg_wwait = wt; cfg_tpc = tpc;
    req_write = wr; req_addr = {row, col}; req_len = len;
    cur_edo = edo; cur_row = row; cur_col = col; wbase = 16'($urandom);
    clear_stats();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!legal) begin
      check(cfg_err == 1'b1, "R6 cfg_err", int'(cfg_err), 1);
      repeat (6) @(negedge clk);
      check(busy == 1'b0 && ras_falls == 0, "R6 ignored", ras_falls + int'(busy), 0);
      return;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    beats    = be ? int'(len) + 1 : 1;
    nh       = tc2 ? 2 : 1;
    nl       = wr ? 1 + int'(wt) : 1;
    exp_busy = 2 + int'(rcd) + beats * (nh + nl) + 1 + int'(tpc);
    check(ras_falls == 1, "R2 ras falls", ras_falls, 1);
    check(cas_falls == beats, "R7 beats", cas_falls, beats);
    check(row_l == row, "R3 row", int'(row_l), int'(row));
    check(first_wait == 1 + int'(rcd) + nh, "R9 ras-to-cas", first_wait, 1 + int'(rcd) + nh);
    check(cashi == 1 + int'(rcd) + beats * nh + 1, "R8 cas high",
          cashi, 1 + int'(rcd) + beats * nh + 1);
    check(caslo == beats * nl, "R10 cas low", caslo, beats * nl);
    check(rash_busy == 1 + int'(tpc), "R11 precharge", rash_busy, 1 + int'(tpc));
    check(busy_cyc == exp_busy, "R11 busy length", busy_cyc, exp_busy);
    check(done_n == beats, "R13 done", done_n, beats);
    if (wr) begin
      check(wr_n == beats && wr_bad == 0, "R12 write data", wr_bad, 0);
      check(rd_n == 0, "R13 no rd_valid on write", rd_n, 0);
    end else begin
      check(rd_n == beats, "R13 rd_valid count", rd_n, beats);
      check(rd_bad == 0, edo ? "R5 edo read data" : "R4 fp read data", rd_bad, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    cfg_edo = 1'b0; cfg_burst = 1'b1; cfg_tcas2 = 1'b0;
    cfg_rcd = '0; cfg_wwait = '0; cfg_tpc = 2'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n && we_n, "R1 strobes high", int'({ras_n, cas_n, we_n}), 7);
    check(!busy && !rd_valid && !done && !dq_oe, "R1 idle outputs",
          int'({busy, rd_valid, done, dq_oe}), 0);

    // directed corners
    do_acc(0, 10'd5, 10'd9, 3'd0, 0, 0, 0, 2'd0, 2'd0, 2'd1, 1);      // minimum timing
    do_acc(0, 10'd77, 10'd1020, 3'd7, 1, 1, 0, 2'd0, 2'd0, 2'd1, 1);  // EDO, column wrap
    do_acc(1, 10'd300, 10'd1022, 3'd7, 0, 1, 1, 2'd3, 2'd3, 2'd3, 1); // write, all max
    do_acc(0, 10'd12, 10'd40, 3'd5, 0, 0, 1, 2'd1, 2'd0, 2'd2, 1);    // R7 burst off
    do_acc(0, 10'd1, 10'd2, 3'd3, 1, 0, 0, 2'd0, 2'd0, 2'd1, 0);      // R6 EDO w/o burst
    do_acc(1, 10'd1, 10'd2, 3'd3, 0, 1, 0, 2'd0, 2'd0, 2'd0, 0);      // R6 zero precharge

    // constrained random
    for (int i = 0; i < 40; i++) begin
      bit r_edo, r_be;
      r_edo = 1'($urandom);
      r_be  = r_edo ? 1'b1 : 1'($urandom);
      do_acc(1'($urandom), 10'($urandom), 10'($urandom), 3'($urandom), r_edo, r_be,
             1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom_range(1, 3)), 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule